// File: doc/BRIEF.md
# Interrupt Entry, Return and Acknowledge Controller

This block sits beside the processor pipeline. It decides when execution leaves the normal flow, either for an external interrupt or for a user exception that software asks for. For each such entry it gives the pipeline three things: a new program counter, a write of the current program counter into a link register, and the new machine status bits. The block itself holds the status bits: interrupt enable, user mode, virtual mode, the saved copies of those two modes, and the load/store reservation flag.

The interrupt source has two entry styles. In vectored (fast) mode the interrupt controller supplies the handler address, and the block sends that controller a one-cycle acknowledge code. In base mode the handler sits at a fixed offset from a configurable vector base. The acknowledge code also tells the controller when a return-from-interrupt executes and when software turns interrupts back on.

All outputs are registered. Each result appears one clock edge after the inputs that caused it are sampled.

Top module: `irq_entry_ctrl`

## Requirements
- R1: When an entry (interrupt or user exception) is taken, `pc_load` is 1. In the same output cycle `link_we` is 1 and `link_data` holds the `cur_pc` value sampled for that entry. For an interrupt entry `link_idx` is 14 (parameter `LINK_IDX`).
- R2: On an interrupt entry, `pc_next` equals `irq_vec` when `fast_mode` is 1, and `VEC_BASE + 0x10` when `fast_mode` is 0.
- R3: `ack` is 2'b01 in the cycle after an interrupt entry taken with `fast_mode` = 1. Base-mode entries and user exceptions produce no 2'b01.
- R4: `ack` is 2'b10 in the cycle after `rti_evt` is sampled high.
- R5: `ack` is 2'b11 in the same cycle in which `ie` changes from 0 to 1 because of a status write. Writing 1 when `ie` is already 1 produces no code.
- R6: Any non-zero `ack` value lasts one cycle. With no new event, `ack` returns to 2'b00.
- R7: An interrupt entry clears `ie` and `resv`, copies `um` into `ums` and `vm` into `vms`, and clears `um` and `vm`.
- R8: A user exception sets `pc_next` to `VEC_BASE + 0x08`, writes the PC to register `uexc_rd`, applies the same mode save/clear and reservation clear as R7, and leaves `ie` unchanged.
- R9: An interrupt is taken only when `irq_req` = 1 and `ie` = 1. When a user exception and an interrupt are both eligible in the same cycle, the user exception wins, and at most one entry happens per cycle.
- R10: When a return event and an enable rising edge occur in the same cycle, `ack` shows 2'b10 in the next cycle and 2'b11 in the cycle after that.
- R11: When an entry and a status write occur in the same cycle, the entry's status updates apply and the write is dropped.
- R12: After reset, `ack` = 00, `pc_load` = 0, `link_we` = 0, and all status bits (`ie`, `um`, `vm`, `ums`, `vms`, `resv`) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | ADDR_W | Program counter of the current instruction |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_vec | input | ADDR_W | Handler address from the controller |
| fast_mode | input | 1 | 1 = use the controller's vector and acknowledge entry |
| uexc_req | input | 1 | Software-requested user exception |
| uexc_rd | input | RIDX_W | Link register index for the user exception |
| rti_evt | input | 1 | Return-from-interrupt executed |
| st_wr | input | 1 | Status write strobe |
| st_wr_ie | input | 1 | Interrupt-enable value to write |
| st_wr_um | input | 1 | User-mode value to write |
| st_wr_vm | input | 1 | Virtual-mode value to write |
| resv_set | input | 1 | Set the reservation flag |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | ADDR_W | Entry target address |
| link_we | output | 1 | Link register write enable |
| link_idx | output | RIDX_W | Link register index |
| link_data | output | ADDR_W | Value written to the link register |
| ack | output | 2 | Acknowledge code to the controller |
| ie | output | 1 | Interrupt enable |
| um | output | 1 | User mode |
| ums | output | 1 | Saved user mode |
| vm | output | 1 | Virtual mode |
| vms | output | 1 | Saved virtual mode |
| resv | output | 1 | Load/store reservation flag |

## Verification
Every entry result (`pc_load`, `pc_next`, link write, status bits) and every `ack` code for a same-cycle event registers on the first rising edge after its inputs are sampled. The bench drives inputs on the falling edge and compares at the next falling edge. A deferred enable code arrives one edge later than the return code, and the bench checks it at the falling edge after that. Each sweep step also holds an idle cycle after the entry, which shows that a code has dropped back to 00 and that no second entry follows.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ACK_NONE     = 2'b00,
    ACK_ENTER    = 2'b01,
    ACK_RETURN   = 2'b10,
    ACK_REENABLE = 2'b11
  } ack_code_e;

  localparam int unsigned OFS_UEXC = 'h08;
  localparam int unsigned OFS_IRQ  = 'h10;
endpackage

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
  parameter int ADDR_W = 32,
  parameter int RIDX_W = 5,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int LINK_IDX = 14
) (
  input  logic              irq_req,
  input  logic              ie,
  input  logic              fast_mode,
  input  logic              uexc_req,
  input  logic [RIDX_W-1:0] uexc_rd,
  input  logic [ADDR_W-1:0] irq_vec,
  output logic              take_irq,
  output logic              take_uexc,
  output logic              fast_enter,
  output logic [ADDR_W-1:0] target,
  output logic [RIDX_W-1:0] dest_idx
);
  import irq_entry_pkg::*;

  localparam logic [ADDR_W-1:0] UEXC_VEC = VEC_BASE + ADDR_W'(OFS_UEXC);
  localparam logic [ADDR_W-1:0] IRQ_VEC  = VEC_BASE + ADDR_W'(OFS_IRQ);

  always_comb begin
    take_uexc  = uexc_req;
    take_irq   = irq_req && ie && !uexc_req;
    fast_enter = take_irq && fast_mode;
    if (take_uexc) begin
      target   = UEXC_VEC;
      dest_idx = uexc_rd;
    end else begin
      target   = fast_mode ? irq_vec : IRQ_VEC;
      dest_idx = RIDX_W'(LINK_IDX);
    end
  end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs (
  input  logic clk,
  input  logic rst,
  input  logic irq_take,
  input  logic uexc_take,
  input  logic wr_en,
  input  logic wr_ie,
  input  logic wr_um,
  input  logic wr_vm,
  input  logic resv_set,
  output logic ie_q,
  output logic um_q,
  output logic ums_q,
  output logic vm_q,
  output logic vms_q,
  output logic resv_q,
  output logic ie_rise
);
  logic entry;

  always_comb begin
    entry   = irq_take || uexc_take;
    ie_rise = !entry && wr_en && wr_ie && !ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      um_q   <= 1'b0;
      ums_q  <= 1'b0;
      vm_q   <= 1'b0;
      vms_q  <= 1'b0;
      resv_q <= 1'b0;
    end else if (entry) begin
      ums_q  <= um_q;
      um_q   <= 1'b0;
      vms_q  <= vm_q;
      vm_q   <= 1'b0;
      resv_q <= 1'b0;
      if (irq_take) ie_q <= 1'b0;
    end else begin
      if (wr_en) begin
        ie_q <= wr_ie;
        um_q <= wr_um;
        vm_q <= wr_vm;
      end
      if (resv_set) resv_q <= 1'b1;
    end
  end

  // R7
  ie_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !ie_q);

  // R8
  uexc_keep_ie_chk: assert property (@(posedge clk) disable iff (rst)
    uexc_take |=> (ie_q == $past(ie_q)));

  // R7
  mode_save_chk: assert property (@(posedge clk) disable iff (rst)
    entry |=> (ums_q == $past(um_q) && vms_q == $past(vm_q) && !um_q && !vm_q && !resv_q));
endmodule

// File: rtl/irq_ack_gen.sv
module irq_ack_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_enter,
  input  logic       ev_ret,
  input  logic       ev_ena,
  output logic [1:0] ack_q
);
  import irq_entry_pkg::*;

  logic pend_ret, pend_ena;
  logic want_ret, want_ena;
  ack_code_e code_d;
  logic pend_ret_d, pend_ena_d;

  always_comb begin
    want_ret   = ev_ret || pend_ret;
    want_ena   = ev_ena || pend_ena;
    pend_ret_d = want_ret;
    pend_ena_d = want_ena;
    code_d     = ACK_NONE;
    if (ev_enter) begin
      code_d = ACK_ENTER;
    end else if (want_ret) begin
      code_d     = ACK_RETURN;
      pend_ret_d = 1'b0;
    end else if (want_ena) begin
      code_d     = ACK_REENABLE;
      pend_ena_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= ACK_NONE;
      pend_ret <= 1'b0;
      pend_ena <= 1'b0;
    end else begin
      ack_q    <= code_d;
      pend_ret <= pend_ret_d;
      pend_ena <= pend_ena_d;
    end
  end

  // R10
  ret_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_ret && ev_ena && !ev_enter) |=> (ack_q == 2'b10));

  // R6
  enter_once_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_q == 2'b01) |=> (ack_q != 2'b01));

  // R4
  ret_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_ret && !ev_enter) |=> (ack_q == 2'b10));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int ADDR_W = 32,
  parameter int RIDX_W = 5,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int LINK_IDX = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] irq_vec,
  input  logic              fast_mode,
  input  logic              uexc_req,
  input  logic [RIDX_W-1:0] uexc_rd,
  input  logic              rti_evt,
  input  logic              st_wr,
  input  logic              st_wr_ie,
  input  logic              st_wr_um,
  input  logic              st_wr_vm,
  input  logic              resv_set,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_next,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [ADDR_W-1:0] link_data,
  output logic [1:0]        ack,
  output logic              ie,
  output logic              um,
  output logic              ums,
  output logic              vm,
  output logic              vms,
  output logic              resv
);
  logic              take_irq, take_uexc, fast_enter, ie_rise;
  logic [ADDR_W-1:0] target;
  logic [RIDX_W-1:0] dest_idx;

  irq_vec_sel #(
    .ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .VEC_BASE(VEC_BASE), .LINK_IDX(LINK_IDX)
  ) u_sel (
    .irq_req(irq_req), .ie(ie), .fast_mode(fast_mode), .uexc_req(uexc_req),
    .uexc_rd(uexc_rd), .irq_vec(irq_vec), .take_irq(take_irq),
    .take_uexc(take_uexc), .fast_enter(fast_enter), .target(target),
    .dest_idx(dest_idx)
  );

  irq_status_regs u_st (
    .clk(clk), .rst(rst), .irq_take(take_irq), .uexc_take(take_uexc),
    .wr_en(st_wr), .wr_ie(st_wr_ie), .wr_um(st_wr_um), .wr_vm(st_wr_vm),
    .resv_set(resv_set), .ie_q(ie), .um_q(um), .ums_q(ums), .vm_q(vm),
    .vms_q(vms), .resv_q(resv), .ie_rise(ie_rise)
  );

  irq_ack_gen u_ack (
    .clk(clk), .rst(rst), .ev_enter(fast_enter), .ev_ret(rti_evt),
    .ev_ena(ie_rise), .ack_q(ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load   <= 1'b0;
      pc_next   <= '0;
      link_we   <= 1'b0;
      link_idx  <= '0;
      link_data <= '0;
    end else begin
      pc_load   <= take_irq || take_uexc;
      link_we   <= take_irq || take_uexc;
      pc_next   <= target;
      link_idx  <= dest_idx;
      link_data <= cur_pc;
    end
  end

  // R1
  link_pair_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (link_we && link_data == $past(cur_pc)));

  // R3
  enter_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack == 2'b01) |-> (pc_load && link_idx == RIDX_W'(LINK_IDX) && !ie));

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !ie && !uexc_req) |=> !pc_load);
endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;
  localparam int AW = 32;
  localparam int RW = 5;
  localparam logic [AW-1:0] BASE = 32'h0000_0100;

  logic clk = 0, rst = 1;
  logic [AW-1:0] cur_pc = 0, irq_vec = 0;
  logic irq_req = 0, fast_mode = 0, uexc_req = 0, rti_evt = 0;
  logic [RW-1:0] uexc_rd = 0;
  logic st_wr = 0, st_wr_ie = 0, st_wr_um = 0, st_wr_vm = 0, resv_set = 0;
  logic pc_load, link_we, ie, um, ums, vm, vms, resv;
  logic [AW-1:0] pc_next, link_data;
  logic [RW-1:0] link_idx;
  logic [1:0] ack;

  int n_chk = 0, n_bad = 0;
  logic exp_ums = 0, exp_vms = 0;

  always #4 clk = ~clk;

  irq_entry_ctrl #(.ADDR_W(AW), .RIDX_W(RW), .VEC_BASE(BASE), .LINK_IDX(14)) u0 (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .irq_req(irq_req), .irq_vec(irq_vec),
    .fast_mode(fast_mode), .uexc_req(uexc_req), .uexc_rd(uexc_rd),
    .rti_evt(rti_evt), .st_wr(st_wr), .st_wr_ie(st_wr_ie), .st_wr_um(st_wr_um),
    .st_wr_vm(st_wr_vm), .resv_set(resv_set), .pc_load(pc_load),
    .pc_next(pc_next), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data), .ack(ack), .ie(ie), .um(um), .ums(ums), .vm(vm),
    .vms(vms), .resv(resv)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    irq_req = 0; uexc_req = 0; rti_evt = 0; st_wr = 0; resv_set = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_status(input logic i, input logic u, input logic v);
    st_wr = 1; st_wr_ie = i; st_wr_um = u; st_wr_vm = v;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst = 0;
    // R12 reset state
    chk("R12 ack", ack, 0); chk("R12 pc_load", pc_load, 0); chk("R12 link_we", link_we, 0);
    chk("R12 status", {ie, um, vm, ums, vms, resv}, 0);

    for (int c = 0; c < 64; c++) begin
      logic ie0, um0, vm0, rq, ux, fm, tu, ti;
      {fm, ux, rq, vm0, um0, ie0} = 6'(c);
      tu = ux; ti = !ux && rq && ie0;
      idle_in(); wr_status(0, um0, vm0); cyc();
      idle_in(); wr_status(ie0, um0, vm0); resv_set = 1; cyc();
      // R5 enable rising edge
      chk("R5 ack on enable", ack, ie0 ? 2'b11 : 2'b00);
      idle_in();
      irq_req = rq; uexc_req = ux; fast_mode = fm;
      cur_pc = 32'h4000 + 32'(c) * 4; irq_vec = 32'h8000 + 32'(c) * 16;
      uexc_rd = 5'(c) ^ 5'h3;
      cyc();
      // R9 gating and priority
      chk("R9 pc_load", pc_load, tu | ti);
      chk("R1 link_we", link_we, tu | ti);
      if (tu | ti) begin
        chk("R1 link_data", link_data, 32'h4000 + 32'(c) * 4);
        chk("R1 link_idx", link_idx, tu ? (5'(c) ^ 5'h3) : 5'd14);
        // R2 and R8 targets
        chk(tu ? "R8 pc_next" : "R2 pc_next", pc_next,
            tu ? BASE + 8 : (fm ? 32'h8000 + 32'(c) * 16 : BASE + 16));
        exp_ums = um0; exp_vms = vm0;
      end
      // R3 entry code
      chk("R3 ack", ack, (ti && fm) ? 2'b01 : 2'b00);
      // R7 and R8 status
      chk("R7 ie", ie, ti ? 1'b0 : ie0);
      chk("R7 um/vm", {um, vm}, (tu | ti) ? 2'b00 : {um0, vm0});
      chk("R7 saved", {ums, vms}, {exp_ums, exp_vms});
      chk("R7 resv", resv, !(tu | ti));
      idle_in(); cyc();
      // R6 return to idle
      chk("R6 ack idle", ack, 0);
      chk("R9 single entry", pc_load, 0);
    end

    // R4 and R6: lone return
    idle_in(); rti_evt = 1; cyc();
    chk("R4 ack", ack, 2'b10);
    idle_in(); cyc();
    chk("R6 ack", ack, 0);

    // R10: return and enable together
    wr_status(0, 0, 0); cyc();
    idle_in(); rti_evt = 1; wr_status(1, 0, 0); cyc();
    chk("R10 first", ack, 2'b10);
    idle_in(); cyc();
    chk("R10 second", ack, 2'b11);
    cyc();
    chk("R10 idle", ack, 0);

    // R5: rewrite of 1 gives no code
    wr_status(1, 0, 0); cyc();
    chk("R5 rewrite", ack, 0);

    // R9: user exception wins over fast interrupt, ie untouched (R8)
    idle_in(); irq_req = 1; uexc_req = 1; fast_mode = 1; uexc_rd = 5'd15; cyc();
    chk("R9 priority pc", pc_next, BASE + 8);
    chk("R9 priority ack", ack, 0);
    chk("R8 ie kept", ie, 1);

    // R11: entry beats same-cycle status write
    idle_in(); wr_status(1, 1, 1); cyc();
    idle_in(); irq_req = 1; fast_mode = 1; wr_status(1, 0, 0); cyc();
    chk("R11 ie", ie, 0);
    chk("R11 saved", {ums, vms, um, vm}, 4'b1100);
    chk("R11 ack", ack, 2'b01);
    idle_in(); cyc();
    chk("R11 ie stays", ie, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule